// File: doc/BRIEF.md
# Byte-Wide Atomic Writer for 16-bit Compare Words

This block sits between an 8-bit processor bus and a bank of 16-bit compare words that a timer compares against continuously. Each word must change in one clock, or the comparator could see half an old value and half a new one. The bridge therefore holds one staging byte that all compare words share. Software writes a word's upper byte first, which only fills the staging byte. It then writes the lower byte, and the bridge commits the staging byte and the lower byte together as one 16-bit value.

A double-buffer enable input chooses where a commit lands. With the enable low, the commit goes straight into the live compare word. With the enable high, it goes into a shadow word per channel. A transfer strobe from the timer copies every shadow into its live word at once, and only while the enable is high.

Reads take bytes straight from the live compare words. They never use the staging byte, because only writes change these words. Each channel has two adjacent bus addresses starting at a parameterized base. The even address is the lower byte and the odd address is the upper byte.

Top module: `cmp16_wr_bridge`

## Requirements
- R1: After reset every live word, every shadow word and the staging byte are zero, and reads return 0x00.
- R2: A write to a channel's upper-byte address (base + 2*ch + 1) only loads the staging byte; no live word changes on the next clock.
- R3: With double buffering off, a write to a channel's lower-byte address (base + 2*ch) sets that channel's live word to {staging byte, written byte} on the next clock edge.
- R4: With double buffering on, a lower-byte write fills that channel's shadow word, and the live words stay unchanged.
- R5: With double buffering on, the transfer strobe copies every shadow word into its live word at the next edge; with double buffering off, the strobe has no effect.
- R6: When a transfer and a lower-byte write fall in the same clock, the live word receives the shadow value from before that clock, and the newly written value waits in the shadow for the next transfer.
- R7: All channels share one staging byte. A lower-byte write uses whatever upper byte was last written to any channel, and the staging byte keeps that value after the commit.
- R8: While the read strobe is high, the read data shows, in the same cycle, the live word's lower byte (even address) or upper byte (odd address). With the strobe low, or for an address outside the map, the read data is 0x00. Reads never change the staging byte.
- R9: Writes to addresses outside the 2*NUM_CH window change no live word, no shadow word and not the staging byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Bus byte address |
| bus_wdata | input | 8 | Write data byte |
| bus_we | input | 1 | Write strobe, one cycle per byte |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| dbuf_en | input | 1 | 1: commits land in shadow words; 0: commits land in live words |
| buf_xfer | input | 1 | Timer event that copies shadow words to live words |
| cmp_word | output | NUM_CH*16 | Live compare words, channel 0 in the lowest bits |

## Verification
The case that matters is a transfer strobe in the same clock as a lower-byte commit into a shadow word. The bench provokes it by writing a fresh upper byte and then raising the transfer strobe in the very cycle the lower byte is written. A reference model copies the old shadow values before it applies the write. It expects the live words to show the pre-collision shadow, and the new value to appear only after a later transfer. A second overlap is the staging byte shared across channels: an upper-byte write to one channel followed by a lower-byte write to another must merge those two bytes.

// File: rtl/cmp16_wr_pkg.sv
package cmp16_wr_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/cmp16_rst_sync.sv
module cmp16_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/cmp16_addr_dec.sv
module cmp16_addr_dec #(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h88,
  parameter int NUM_CH    = 3,
  parameter int CH_W      = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              hi_sel,
  output logic [CH_W-1:0]   ch_sel
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] SPAN_V = ADDR_W'(2 * NUM_CH);

  logic [ADDR_W-1:0] off;

  always_comb begin
    off    = addr - BASE_V;
    hit    = (addr >= BASE_V) && (off < SPAN_V);
    hi_sel = off[0];
    ch_sel = CH_W'(off >> 1);
  end
endmodule

// File: rtl/cmp16_stage_byte.sv
module cmp16_stage_byte
  import cmp16_wr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_sn,
  input  logic  load_en,
  input  byte_t din,
  output byte_t q
);
  byte_t d;

  always_comb begin
    d = q;
    if (load_en) d = din;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) q <= '0;
    else         q <= d;
  end
endmodule

// File: rtl/cmp16_chan.sv
module cmp16_chan
  import cmp16_wr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_sn,
  input  logic  commit,
  input  word_t commit_word,
  input  logic  dbuf_en,
  input  logic  xfer,
  output word_t live_q
);
  word_t shadow_q, shadow_d, live_d;

  always_comb begin
    shadow_d = shadow_q;
    live_d   = live_q;
    if (dbuf_en && xfer) live_d = shadow_q;
    if (commit) begin
      if (dbuf_en) shadow_d = commit_word;
      else         live_d   = commit_word;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      shadow_q <= '0;
      live_q   <= '0;
    end else begin
      shadow_q <= shadow_d;
      live_q   <= live_d;
    end
  end
endmodule

// File: rtl/cmp16_rd_mux.sv
module cmp16_rd_mux
  import cmp16_wr_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int CH_W   = 2
) (
  input  logic [NUM_CH*WORD_W-1:0] words,
  input  logic                     re,
  input  logic                     hit,
  input  logic                     hi_sel,
  input  logic [CH_W-1:0]          ch_sel,
  output byte_t                    rdata
);
  word_t pick;

  always_comb begin
    pick = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel == CH_W'(c)) pick = words[c*WORD_W +: WORD_W];
    end
    rdata = '0;
    if (re && hit) rdata = hi_sel ? pick[WORD_W-1:BYTE_W] : pick[BYTE_W-1:0];
  end
endmodule

// File: rtl/cmp16_wr_bridge.sv
module cmp16_wr_bridge
  import cmp16_wr_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h88,
  parameter int NUM_CH    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [7:0]               bus_wdata,
  input  logic                     bus_we,
  input  logic                     bus_re,
  output logic [7:0]               bus_rdata,
  input  logic                     dbuf_en,
  input  logic                     buf_xfer,
  output logic [NUM_CH*16-1:0]     cmp_word
);
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic            rst_sn;
  logic            hit, hi_sel;
  logic [CH_W-1:0] ch_sel;
  logic            stage_we;
  byte_t           stage_q;

  cmp16_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  cmp16_addr_dec #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_CH(NUM_CH), .CH_W(CH_W)
  ) u_dec (
    .addr(bus_addr), .hit(hit), .hi_sel(hi_sel), .ch_sel(ch_sel)
  );

  assign stage_we = bus_we && hit && hi_sel;

  cmp16_stage_byte u_stage (
    .clk(clk), .rst_sn(rst_sn), .load_en(stage_we), .din(bus_wdata), .q(stage_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic commit;
    assign commit = bus_we && hit && !hi_sel && (ch_sel == CH_W'(c));
    cmp16_chan u_chan (
      .clk(clk), .rst_sn(rst_sn), .commit(commit),
      .commit_word({stage_q, bus_wdata}), .dbuf_en(dbuf_en), .xfer(buf_xfer),
      .live_q(cmp_word[c*WORD_W +: WORD_W])
    );
  end

  cmp16_rd_mux #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_rd (
    .words(cmp_word), .re(bus_re), .hit(hit), .hi_sel(hi_sel),
    .ch_sel(ch_sel), .rdata(bus_rdata)
  );
endmodule

// File: rtl/cmp16_wr_bridge_chk.sv
module cmp16_wr_bridge_chk #(
  parameter int ADDR_W    = 8,
  parameter int BASE_ADDR = 'h88,
  parameter int NUM_CH    = 3
) (
  input logic                 clk,
  input logic                 rst_sn,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [7:0]           bus_wdata,
  input logic                 bus_we,
  input logic                 bus_re,
  input logic [7:0]           bus_rdata,
  input logic                 dbuf_en,
  input logic                 buf_xfer,
  input logic [7:0]           stage_q,
  input logic [NUM_CH*16-1:0] cmp_word
);
  AST_XFER_IGNORED: assert property (@(posedge clk) disable iff (!rst_sn)
    (buf_xfer && !dbuf_en && !bus_we) |=> $stable(cmp_word)); // R5
  AST_READ_KEEPS_STAGE: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_re && !bus_we) |=> $stable(stage_q)); // R8
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (!rst_sn)
    (!bus_re) |-> (bus_rdata == 8'h00)); // R8

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(BASE_ADDR + 2 * c);
    localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(BASE_ADDR + 2 * c + 1);
    AST_HI_ONLY_STAGES: assert property (@(posedge clk) disable iff (!rst_sn)
      (bus_we && bus_addr == HI_A && !buf_xfer) |=> $stable(cmp_word)); // R2
    AST_DIRECT_COMMIT: assert property (@(posedge clk) disable iff (!rst_sn)
      (bus_we && bus_addr == LO_A && !dbuf_en)
      |=> (cmp_word[c*16 +: 16] == {$past(stage_q), $past(bus_wdata)})); // R3
    AST_SHADOW_HOLDS_LIVE: assert property (@(posedge clk) disable iff (!rst_sn)
      (bus_we && bus_addr == LO_A && dbuf_en && !buf_xfer) |=> $stable(cmp_word)); // R4
  end
endmodule

bind cmp16_wr_bridge cmp16_wr_bridge_chk #(
  .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_CH(NUM_CH)
) u_chk (
  .clk(clk), .rst_sn(rst_sn), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .dbuf_en(dbuf_en),
  .buf_xfer(buf_xfer), .stage_q(stage_q), .cmp_word(cmp_word)
);

// File: tb/cmp16_wr_bridge_test.sv
`timescale 1ns/1ps
module cmp16_wr_bridge_test;
  localparam int AW = 8;
  localparam int BASE = 'h88;
  localparam int NCH = 3;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [AW-1:0]   addr;
  logic [7:0]      wdata;
  logic            we, re, dbuf, xfer;
  logic [7:0]      rdata;
  logic [NCH*16-1:0] cmp;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] m_live [NCH];
  logic [15:0] m_shadow [NCH];
  logic [7:0]  m_stage;

  always #10 clk = ~clk;

  cmp16_wr_bridge #(.ADDR_W(AW), .BASE_ADDR(BASE), .NUM_CH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata),
    .bus_we(we), .bus_re(re), .bus_rdata(rdata), .dbuf_en(dbuf),
    .buf_xfer(xfer), .cmp_word(cmp)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit mapped(input int a);
    return (a >= BASE) && (a < BASE + 2 * NCH);
  endfunction

  task automatic compare_live(input string req);
    for (int c = 0; c < NCH; c++)
      chk(cmp[c*16 +: 16] === m_live[c], req, $sformatf("live word ch%0d", c),
          32'(cmp[c*16 +: 16]), 32'(m_live[c]));
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic step(input int a, input logic [7:0] d, input bit w, input bit r,
                      input bit db, input bit x, input string req);
    logic [7:0]  exp_rd;
    logic [15:0] old_shadow [NCH];
    int off;
    addr = AW'(a); wdata = d; we = w; re = r; dbuf = db; xfer = x;
    #1;
    exp_rd = 8'h00;
    off = a - BASE;
    if (r && mapped(a))
      exp_rd = (off % 2) ? m_live[off / 2][15:8] : m_live[off / 2][7:0];
    chk(rdata === exp_rd, req, "read data", 32'(rdata), 32'(exp_rd));
    @(posedge clk);
    for (int c = 0; c < NCH; c++) old_shadow[c] = m_shadow[c];
    if (db && x)
      for (int c = 0; c < NCH; c++) m_live[c] = old_shadow[c];
    if (w && mapped(a)) begin
      if (off % 2) m_stage = d;
      else if (db) m_shadow[off / 2] = {m_stage, d};
      else         m_live[off / 2]   = {m_stage, d};
    end
    @(negedge clk);
    we = 0; re = 0; xfer = 0;
    compare_live(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; we = 0; re = 0; dbuf = 0; xfer = 0;
    for (int c = 0; c < NCH; c++) begin m_live[c] = '0; m_shadow[c] = '0; end
    m_stage = '0;
    repeat (3) @(negedge clk);
    compare_live("R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state through reads
    for (int a = BASE; a < BASE + 2 * NCH; a++) step(a, 8'h00, 0, 1, 0, 0, "R1");
    // R2 / R3: upper byte stages, lower byte commits directly
    step(BASE + 1, 8'hAB, 1, 0, 0, 0, "R2");
    step(BASE + 0, 8'hCD, 1, 0, 0, 0, "R3");
    // R8: read both bytes, idle read strobe, unmapped read
    step(BASE + 0, 8'h00, 0, 1, 0, 0, "R8");
    step(BASE + 1, 8'h00, 0, 1, 0, 0, "R8");
    step(BASE + 1, 8'h00, 0, 0, 0, 0, "R8");
    step(BASE + 2 * NCH, 8'h00, 0, 1, 0, 0, "R8");
    // R4 / R5: shadow fill then transfer
    step(BASE + 3, 8'h12, 1, 0, 1, 0, "R4");
    step(BASE + 2, 8'h34, 1, 0, 1, 0, "R4");
    step(BASE + 3, 8'h00, 0, 1, 1, 0, "R4");
    step(BASE + 0, 8'h00, 0, 0, 1, 1, "R5");
    step(BASE + 2, 8'h00, 0, 1, 0, 0, "R5");
    // R5: strobe ignored with double buffering off (shadow of ch1 differs? make it)
    step(BASE + 3, 8'h77, 1, 0, 1, 0, "R5");
    step(BASE + 2, 8'h88, 1, 0, 1, 0, "R5");
    step(BASE + 0, 8'h00, 0, 0, 0, 1, "R5");
    // R6: transfer and lower-byte commit in the same cycle
    step(BASE + 5, 8'h55, 1, 0, 1, 0, "R6");
    step(BASE + 4, 8'h66, 1, 0, 1, 1, "R6");
    step(BASE + 4, 8'h00, 0, 1, 1, 0, "R6");
    step(BASE + 0, 8'h00, 0, 0, 1, 1, "R6");
    step(BASE + 5, 8'h00, 0, 1, 1, 0, "R6");
    // R7: staging byte shared across channels and kept after commit
    step(BASE + 1, 8'h9A, 1, 0, 0, 0, "R7");
    step(BASE + 4, 8'h01, 1, 0, 0, 0, "R7");
    step(BASE + 2, 8'h02, 1, 0, 0, 0, "R7");
    // R8: read between staging and commit does not disturb the staging byte
    step(BASE + 1, 8'h3C, 1, 0, 0, 0, "R8");
    step(BASE + 1, 8'h00, 0, 1, 0, 0, "R8");
    step(BASE + 0, 8'hC3, 1, 0, 0, 0, "R8");
    // R9: unmapped writes leave live, shadow and staging untouched
    step(BASE + 2 * NCH, 8'hEE, 1, 0, 0, 0, "R9");
    step(BASE - 1, 8'hDD, 1, 0, 1, 0, "R9");
    step(BASE + 2, 8'h44, 1, 0, 0, 0, "R9");
    step(BASE + 0, 8'h00, 0, 0, 1, 1, "R9");
    step(BASE + 2, 8'h00, 0, 1, 1, 0, "R9");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule